// File: doc/BRIEF.md
# Hot-Routine Detector and Translation Redirect

This block sits beside the branch unit and the fetch unit of a core that can run code either as decoded ordinary instructions or as software-optimized native sequences. It profiles the branch targets that retire, counting how often each routine entry point is reached. Once a routine is reached often enough, the block raises a request that hands control to the optimizer routine. It raises the same kind of request, tagged as re-optimization, when the predictor reverses its direction for a branch that lies inside already-optimized code.

A second structure holds the mapping from original routine addresses to the addresses of their optimized versions. The optimizer fills it through an install port. Every fetch-target lookup searches it. A hit steers fetch to the optimized address. A miss leaves fetch at the original address.

Only one request is outstanding at a time. A request stays up until the consumer acknowledges it. Profiling state lives in a direct-mapped counter table, and the redirect mapping lives in a small fully associative table.

Top module: `hot_route_unit`

## Requirements
- R1: Counts are kept in 64 direct-mapped entries. The entry is selected by `br_target[5:0]` and tagged with `br_target[31:6]`. A retired target whose tag differs from the stored tag takes over the entry with a count of 1 and no pending mark.
- R2: A hot request is raised when the updated count of the entry is greater than or equal to `hot_thresh`. It appears as a one-cycle `req_fire` pulse with `req_kind`=0 and `req_addr` equal to the target, in the cycle after the branch is presented.
- R3: An entry that has raised a hot request is marked pending and raises no further hot request. An install whose source address matches the entry, or a clear request for its address, removes the mark and sets the count to 0.
- R4: Counts saturate at 255 and never wrap.
- R5: A lookup is answered in the next cycle through `fetch_valid`. On a hit, `fetch_redirect`=1 and `fetch_pc` is the optimized address. The lookup sees the map as it stood before any install or invalidate in the same cycle.
- R6: A lookup that misses gives `fetch_redirect`=0 and `fetch_pc` equal to the address that was looked up.
- R7: The map holds 16 entries. Installing a source address that is already present overwrites that entry's destination in place. Installing a new source uses the next slot in round-robin order, so the 17th distinct install evicts the first one.
- R8: `inv_all` clears every map entry and resets the round-robin slot. A lookup made after it misses.
- R9: A reversal with `flip_xlat`=1 raises a request with `req_kind`=1 and `req_addr`=`flip_pc`, two cycles after it is presented if the slot is free. A reversal with `flip_xlat`=0 is ignored.
- R10: While `req_busy` is high no new request fires, and `req_addr`/`req_kind` hold their values. A reversal seen while busy is held (a later one replaces it) and fires first once the slot frees. A threshold crossing seen while busy or while a reversal is held is not marked pending, so it fires at the first encounter after the slot frees. `req_ack` frees the slot in the cycle it is seen.
- R11: After reset, `req_fire`, `req_busy`, `fetch_valid` and `fetch_redirect` are 0, every count is 0 and the map is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch target retires this cycle |
| br_target | input | 32 | Retired branch target address |
| hot_thresh | input | 8 | Encounter count that makes a routine hot |
| flip_valid | input | 1 | Predictor reversed a branch direction |
| flip_pc | input | 32 | Address of the reversed branch |
| flip_xlat | input | 1 | The reversed branch lies in optimized code |
| inst_valid | input | 1 | Install a map entry |
| inst_src | input | 32 | Original routine address to install |
| inst_dst | input | 32 | Optimized code address to install |
| clr_valid | input | 1 | Drop the pending mark and count for an address |
| clr_addr | input | 32 | Address whose counter entry is cleared |
| inv_all | input | 1 | Invalidate the whole map |
| lk_valid | input | 1 | Fetch-target lookup request |
| lk_addr | input | 32 | Fetch target to look up |
| req_ack | input | 1 | Consumer accepted the outstanding request |
| req_fire | output | 1 | One-cycle strobe of a new request |
| req_kind | output | 1 | 0 = hot routine, 1 = re-optimization |
| req_addr | output | 32 | Address carried by the request |
| req_busy | output | 1 | A request is outstanding |
| fetch_valid | output | 1 | Lookup answer valid |
| fetch_redirect | output | 1 | Lookup hit: fetch goes to the optimized address |
| fetch_pc | output | 32 | Address fetch continues from |

## Verification
A hot request is due one cycle after the crossing branch, a reversal request two cycles after the reversal, and a lookup answer one cycle after the lookup. Every stimulus is driven on a falling edge. The outputs it causes are sampled on the next falling edge, which is after exactly one registering edge. For reversals, one idle step is added before the request is expected. Long runs of branches under a busy slot count any stray strobe in every step, so an early or extra request is caught where it happens.

// File: rtl/hrd_pkg.sv
package hrd_pkg;
    typedef enum logic {
        KIND_HOT   = 1'b0,
        KIND_REOPT = 1'b1
    } req_kind_e;
endpackage

// File: rtl/hrd_count_tbl.sv
module hrd_count_tbl #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 64,
    parameter int CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_target,
    input  logic [CNT_W-1:0]  thresh,
    input  logic              hot_grant,
    input  logic [1:0]        rel_valid,
    input  logic [ADDR_W-1:0] rel_addr [2],
    output logic              hot_now,
    output logic [ADDR_W-1:0] hot_addr
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             vld;
        logic             pend;
        logic [TAG_W-1:0] tag;
        logic [CNT_W-1:0] cnt;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
    } st_t;

    st_t  st_q, st_d;
    ent_t cur;
    logic [IDX_W-1:0] b_idx;
    logic [TAG_W-1:0] b_tag;

    assign b_idx = br_target[IDX_W-1:0];
    assign b_tag = br_target[ADDR_W-1:IDX_W];

    always_comb begin
        st_d     = st_q;
        hot_now  = 1'b0;
        hot_addr = br_target;
        // release: installed or declined routines start counting afresh
        for (int r = 0; r < 2; r++) begin
            if (rel_valid[r]
                && st_d.ent[rel_addr[r][IDX_W-1:0]].vld
                && st_d.ent[rel_addr[r][IDX_W-1:0]].tag == rel_addr[r][ADDR_W-1:IDX_W]) begin
                st_d.ent[rel_addr[r][IDX_W-1:0]].pend = 1'b0;
                st_d.ent[rel_addr[r][IDX_W-1:0]].cnt  = '0;
            end
        end
        cur = st_d.ent[b_idx];
        if (br_valid) begin
            if (cur.vld && cur.tag == b_tag) begin
                if (cur.cnt != CNT_MAX) begin
                    cur.cnt = cur.cnt + CNT_W'(1);
                end
            end else begin
                cur.vld  = 1'b1;
                cur.pend = 1'b0;
                cur.tag  = b_tag;
                cur.cnt  = CNT_W'(1);
            end
            if (!cur.pend && cur.cnt >= thresh && hot_grant) begin
                cur.pend = 1'b1;
                hot_now  = 1'b1;
            end
            st_d.ent[b_idx] = cur;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/hrd_xlat_map.sv
module hrd_xlat_map #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inst_valid,
    input  logic [ADDR_W-1:0] inst_src,
    input  logic [ADDR_W-1:0] inst_dst,
    input  logic              inv_all,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              fetch_valid,
    output logic              fetch_redirect,
    output logic [ADDR_W-1:0] fetch_pc
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
        logic [PTR_W-1:0]    ptr;
        logic                f_valid;
        logic                f_redir;
        logic [ADDR_W-1:0]   f_pc;
    } st_t;

    st_t st_q, st_d;
    logic              lk_hit;
    logic [ADDR_W-1:0] lk_dst;
    logic              in_hit;
    logic [PTR_W-1:0]  in_slot;

    always_comb begin
        lk_hit  = 1'b0;
        lk_dst  = '0;
        in_hit  = 1'b0;
        in_slot = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!lk_hit && st_q.slot[i].vld && st_q.slot[i].src == lk_addr) begin
                lk_hit = 1'b1;
                lk_dst = st_q.slot[i].dst;
            end
            if (!in_hit && st_q.slot[i].vld && st_q.slot[i].src == inst_src) begin
                in_hit  = 1'b1;
                in_slot = PTR_W'(i);
            end
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.f_valid = lk_valid;
        st_d.f_redir = lk_valid && lk_hit;
        st_d.f_pc    = lk_hit ? lk_dst : lk_addr;
        if (inv_all) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.slot[i].vld = 1'b0;
            end
            st_d.ptr = '0;
        end else if (inst_valid) begin
            if (in_hit) begin
                st_d.slot[in_slot].dst = inst_dst;
            end else begin
                st_d.slot[st_q.ptr].vld = 1'b1;
                st_d.slot[st_q.ptr].src = inst_src;
                st_d.slot[st_q.ptr].dst = inst_dst;
                st_d.ptr = (st_q.ptr == PTR_LAST) ? '0 : st_q.ptr + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_valid    = st_q.f_valid;
    assign fetch_redirect = st_q.f_redir;
    assign fetch_pc       = st_q.f_pc;
endmodule

// File: rtl/hrd_req_arb.sv
module hrd_req_arb
    import hrd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hot_now,
    input  logic [ADDR_W-1:0] hot_addr,
    input  logic              flip_valid,
    input  logic [ADDR_W-1:0] flip_pc,
    input  logic              flip_xlat,
    input  logic              req_ack,
    output logic              hot_grant,
    output logic              req_fire,
    output req_kind_e         req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_busy
);
    typedef struct packed {
        logic              busy;
        logic              fire;
        req_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic              hold_v;
        logic [ADDR_W-1:0] hold_addr;
    } st_t;

    st_t st_q, st_d;

    assign hot_grant = !st_q.busy && !st_q.hold_v;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (st_q.busy && req_ack) begin
            st_d.busy = 1'b0;
        end
        if (!st_q.busy) begin
            if (st_q.hold_v) begin
                st_d.busy   = 1'b1;
                st_d.fire   = 1'b1;
                st_d.kind   = KIND_REOPT;
                st_d.addr   = st_q.hold_addr;
                st_d.hold_v = 1'b0;
            end else if (hot_now) begin
                st_d.busy = 1'b1;
                st_d.fire = 1'b1;
                st_d.kind = KIND_HOT;
                st_d.addr = hot_addr;
            end
        end
        if (flip_valid && flip_xlat) begin
            st_d.hold_v    = 1'b1;
            st_d.hold_addr = flip_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_fire = st_q.fire;
    assign req_kind = st_q.kind;
    assign req_addr = st_q.addr;
    assign req_busy = st_q.busy;
endmodule

// File: rtl/hot_route_unit.sv
module hot_route_unit
    import hrd_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_ENTRIES = 64,
    parameter int CNT_W       = 8,
    parameter int MAP_ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_target,
    input  logic [CNT_W-1:0]  hot_thresh,
    input  logic              flip_valid,
    input  logic [ADDR_W-1:0] flip_pc,
    input  logic              flip_xlat,
    input  logic              inst_valid,
    input  logic [ADDR_W-1:0] inst_src,
    input  logic [ADDR_W-1:0] inst_dst,
    input  logic              clr_valid,
    input  logic [ADDR_W-1:0] clr_addr,
    input  logic              inv_all,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              req_ack,
    output logic              req_fire,
    output logic              req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_busy,
    output logic              fetch_valid,
    output logic              fetch_redirect,
    output logic [ADDR_W-1:0] fetch_pc
);
    logic              hot_now;
    logic [ADDR_W-1:0] hot_addr;
    logic              hot_grant;
    logic [1:0]        rel_valid;
    logic [ADDR_W-1:0] rel_addr [2];
    req_kind_e         kind_w;

    assign rel_valid   = {clr_valid, inst_valid};
    assign rel_addr[0] = inst_src;
    assign rel_addr[1] = clr_addr;

    hrd_count_tbl #(
        .ADDR_W (ADDR_W),
        .ENTRIES(CNT_ENTRIES),
        .CNT_W  (CNT_W)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .br_valid (br_valid),
        .br_target(br_target),
        .thresh   (hot_thresh),
        .hot_grant(hot_grant),
        .rel_valid(rel_valid),
        .rel_addr (rel_addr),
        .hot_now  (hot_now),
        .hot_addr (hot_addr)
    );

    hrd_req_arb #(
        .ADDR_W(ADDR_W)
    ) arb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hot_now   (hot_now),
        .hot_addr  (hot_addr),
        .flip_valid(flip_valid),
        .flip_pc   (flip_pc),
        .flip_xlat (flip_xlat),
        .req_ack   (req_ack),
        .hot_grant (hot_grant),
        .req_fire  (req_fire),
        .req_kind  (kind_w),
        .req_addr  (req_addr),
        .req_busy  (req_busy)
    );

    assign req_kind = kind_w;

    hrd_xlat_map #(
        .ADDR_W (ADDR_W),
        .ENTRIES(MAP_ENTRIES)
    ) map_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .inst_valid    (inst_valid),
        .inst_src      (inst_src),
        .inst_dst      (inst_dst),
        .inv_all       (inv_all),
        .lk_valid      (lk_valid),
        .lk_addr       (lk_addr),
        .fetch_valid   (fetch_valid),
        .fetch_redirect(fetch_redirect),
        .fetch_pc      (fetch_pc)
    );
endmodule

// File: rtl/hrd_checker.sv
module hrd_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inv_all,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              req_ack,
    input logic              req_fire,
    input logic              req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_busy,
    input logic              fetch_valid,
    input logic              fetch_redirect,
    input logic [ADDR_W-1:0] fetch_pc
);
    p_fire_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire |=> !req_fire);

    p_fire_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire |-> req_busy);

    p_hold_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_busy && !req_ack) |=> (!req_fire && $stable(req_addr) && $stable(req_kind)));

    p_answer_due_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> fetch_valid);

    p_no_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !fetch_valid);

    p_miss_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (fetch_redirect || fetch_pc == $past(lk_addr)));

    p_empty_after_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inv_all) && lk_valid) |=> !fetch_redirect);
endmodule

bind hot_route_unit hrd_checker #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/hot_route_unit_tb.sv
module hot_route_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    localparam logic [2:0] OP_NOP  = 3'd0;
    localparam logic [2:0] OP_BR   = 3'd1;
    localparam logic [2:0] OP_LK   = 3'd2;
    localparam logic [2:0] OP_INST = 3'd3;
    localparam logic [2:0] OP_FLIP = 3'd4;
    localparam logic [2:0] OP_ACK  = 3'd5;
    localparam logic [2:0] OP_INV  = 3'd6;
    localparam logic [2:0] OP_CLR  = 3'd7;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        efire;
        logic        ekind;
        logic [31:0] eaddr;
        logic        eredir;
        logic [31:0] epc;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    // thresh = 3 for the whole table
    localparam vec_t VECS [NV] = '{
        '{OP_BR,   32'h100, 32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd2},  // R2 count 1
        '{OP_BR,   32'h100, 32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd2},  // R2 count 2
        '{OP_BR,   32'h100, 32'h0,    1'b1, 1'b0, 32'h100, 1'b0, 32'h0,    8'd2},  // R2 crossing
        '{OP_BR,   32'h100, 32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd10}, // R10 busy
        '{OP_ACK,  32'h0,   32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd10},
        '{OP_BR,   32'h100, 32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd3},  // R3 pending
        '{OP_LK,   32'h100, 32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h100,  8'd6},  // R6 miss
        '{OP_INST, 32'h100, 32'h8000, 1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd3},
        '{OP_LK,   32'h100, 32'h0,    1'b0, 1'b0, 32'h0,   1'b1, 32'h8000, 8'd5},  // R5 hit
        '{OP_BR,   32'h100, 32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd3},  // R3 count reset
        '{OP_FLIP, 32'h104, 32'h1,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd9},
        '{OP_NOP,  32'h0,   32'h0,    1'b1, 1'b1, 32'h104, 1'b0, 32'h0,    8'd9},  // R9 reopt
        '{OP_ACK,  32'h0,   32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd10},
        '{OP_FLIP, 32'h200, 32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd9},
        '{OP_NOP,  32'h0,   32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd9},  // R9 ignored
        '{OP_BR,   32'h140, 32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd1},  // R1 replace
        '{OP_BR,   32'h140, 32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd1},
        '{OP_BR,   32'h100, 32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd1},  // R1 replace back
        '{OP_BR,   32'h100, 32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd1},
        '{OP_BR,   32'h100, 32'h0,    1'b1, 1'b0, 32'h100, 1'b0, 32'h0,    8'd1},
        '{OP_ACK,  32'h0,   32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd10},
        '{OP_INV,  32'h0,   32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,    8'd8},
        '{OP_LK,   32'h100, 32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h100,  8'd8},  // R8 cleared
        '{OP_LK,   32'h140, 32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h140,  8'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        br_valid, flip_valid, flip_xlat, inst_valid, clr_valid;
    logic        inv_all, lk_valid, req_ack;
    logic [31:0] br_target, flip_pc, inst_src, inst_dst, clr_addr, lk_addr;
    logic [7:0]  hot_thresh;
    logic        req_fire, req_kind, req_busy, fetch_valid, fetch_redirect;
    logic [31:0] req_addr, fetch_pc;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hot_route_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_target(br_target), .hot_thresh(hot_thresh),
        .flip_valid(flip_valid), .flip_pc(flip_pc), .flip_xlat(flip_xlat),
        .inst_valid(inst_valid), .inst_src(inst_src), .inst_dst(inst_dst),
        .clr_valid(clr_valid), .clr_addr(clr_addr), .inv_all(inv_all),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .req_ack(req_ack),
        .req_fire(req_fire), .req_kind(req_kind), .req_addr(req_addr),
        .req_busy(req_busy), .fetch_valid(fetch_valid),
        .fetch_redirect(fetch_redirect), .fetch_pc(fetch_pc)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        br_valid = 0; flip_valid = 0; flip_xlat = 0; inst_valid = 0;
        clr_valid = 0; inv_all = 0; lk_valid = 0; req_ack = 0;
        br_target = 0; flip_pc = 0; inst_src = 0; inst_dst = 0;
        clr_addr = 0; lk_addr = 0;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        idle_inputs();
        case (op)
            OP_BR:   begin br_valid = 1; br_target = a; end
            OP_LK:   begin lk_valid = 1; lk_addr = a; end
            OP_INST: begin inst_valid = 1; inst_src = a; inst_dst = b; end
            OP_FLIP: begin flip_valid = 1; flip_pc = a; flip_xlat = b[0]; end
            OP_ACK:  req_ack = 1;
            OP_INV:  inv_all = 1;
            OP_CLR:  begin clr_valid = 1; clr_addr = a; end
            default: ;
        endcase
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        int stray;
        hot_thresh = 8'd3;
        @(negedge clk);
        do_reset();
        // R11 reset state
        chk("R11 req_fire", {31'b0, req_fire}, 0);
        chk("R11 req_busy", {31'b0, req_busy}, 0);
        chk("R11 fetch_valid", {31'b0, fetch_valid}, 0);
        chk("R11 fetch_redirect", {31'b0, fetch_redirect}, 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            step(VECS[i].op, VECS[i].a, VECS[i].b);
            tag = $sformatf("R%0d table step %0d", VECS[i].req, i);
            chk({tag, " fire"}, {31'b0, req_fire}, {31'b0, VECS[i].efire});
            if (VECS[i].efire) begin
                chk({tag, " kind"}, {31'b0, req_kind}, {31'b0, VECS[i].ekind});
                chk({tag, " addr"}, req_addr, VECS[i].eaddr);
            end
            if (VECS[i].op == OP_LK) begin
                chk({tag, " redirect"}, {31'b0, fetch_redirect}, {31'b0, VECS[i].eredir});
                chk({tag, " pc"}, fetch_pc, VECS[i].epc);
            end
        end

        // R7: round-robin replacement and in-place overwrite
        do_reset();
        for (int i = 0; i < 17; i++) step(OP_INST, 32'h1000 + 32'(i * 4), 32'h9000 + 32'(i));
        step(OP_LK, 32'h1000, 0);
        chk("R7 evicted redirect", {31'b0, fetch_redirect}, 0);
        chk("R7 evicted pc", fetch_pc, 32'h1000);
        step(OP_LK, 32'h1040, 0);
        chk("R7 newest pc", fetch_pc, 32'h9010);
        step(OP_INST, 32'h1004, 32'hAAAA);
        step(OP_LK, 32'h1004, 0);
        chk("R7 overwrite pc", fetch_pc, 32'hAAAA);
        step(OP_INST, 32'h2000, 32'hBBBB);
        step(OP_LK, 32'h1008, 0);
        chk("R7 slot2 kept", fetch_pc, 32'h9002);
        step(OP_LK, 32'h1004, 0);
        chk("R7 slot1 evicted", {31'b0, fetch_redirect}, 0);
        step(OP_LK, 32'h2000, 0);
        chk("R7 new entry pc", fetch_pc, 32'hBBBB);

        // R10 / R4: hold-back, reversal priority and saturation
        do_reset();
        hot_thresh = 8'd255;
        step(OP_FLIP, 32'h500, 1);
        step(OP_NOP, 0, 0);
        chk("R9 reopt fire", {31'b0, req_fire}, 1);
        chk("R9 reopt addr", req_addr, 32'h500);
        stray = 0;
        for (int i = 0; i < 300; i++) begin
            if (i == 150) step(OP_FLIP, 32'h700, 1);
            step(OP_BR, 32'h600, 0);
            if (req_fire) stray++;
        end
        chk("R10 no fire while busy", 32'(stray), 0);
        chk("R10 addr held", req_addr, 32'h500);
        step(OP_ACK, 0, 0);
        chk("R10 no fire on ack", {31'b0, req_fire}, 0);
        step(OP_NOP, 0, 0);
        chk("R10 held reversal fires", {31'b0, req_fire}, 1);
        chk("R10 held reversal kind", {31'b0, req_kind}, 1);
        chk("R10 held reversal addr", req_addr, 32'h700);
        step(OP_ACK, 0, 0);
        step(OP_BR, 32'h600, 0);
        chk("R4 saturated count fires", {31'b0, req_fire}, 1);
        chk("R4 hot addr", req_addr, 32'h600);
        chk("R4 hot kind", {31'b0, req_kind}, 0);
        step(OP_ACK, 0, 0);

        // R3: clear drops the mark and restarts the count
        hot_thresh = 8'd3;
        step(OP_BR, 32'h800, 0);
        step(OP_BR, 32'h800, 0);
        chk("R2 below threshold", {31'b0, req_fire}, 0);
        step(OP_BR, 32'h800, 0);
        chk("R2 at threshold", {31'b0, req_fire}, 1);
        step(OP_ACK, 0, 0);
        step(OP_BR, 32'h800, 0);
        chk("R3 pending blocks", {31'b0, req_fire}, 0);
        step(OP_CLR, 32'h800, 0);
        step(OP_BR, 32'h800, 0);
        step(OP_BR, 32'h800, 0);
        chk("R3 count restarted", {31'b0, req_fire}, 0);
        step(OP_BR, 32'h800, 0);
        chk("R3 refires after clear", {31'b0, req_fire}, 1);
        chk("R3 refire addr", req_addr, 32'h800);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule